// File: doc/BRIEF.md
# Majority-Vote Glitch-Robust Edge Detector

This block sits on an asynchronous serial receive line. It produces a filtered, synchronized copy of the line level and single-cycle pulses that mark rising and falling transitions. Clock-recovery logic downstream relies on these pulses. A glitch narrower than one system-clock period must therefore never create an edge. The filtered level is delayed so that it changes in the same cycle as the matching edge pulse.

The line first passes through a two-flop synchronizer. It then enters a six-tap sample window. The window is split into a newer half and an older half, and each half is reduced to a two-out-of-three majority. An edge is declared when the two majorities disagree. After each declared edge, a hold-off timer blocks detection for a configurable number of cycles. Candidates that fall inside that window are dropped, not deferred. After reset every stage holds the idle level of the line, so start-up produces no edge.

Top module: `line_edge_voter`

## Requirements
- R1: While reset is low, and after it is released with the line at the idle level (IDLE_LEVEL, default 1), data_o equals IDLE_LEVEL and rise_o and fall_o stay 0. Before the release, samples count as idle.
- R2: If the line goes from 0 to 1 and is first sampled high by clock edge n, then held, rise_o is 1 in the cycle after edge n+4 only.
- R3: The mirror case of R2: a 1-to-0 change first sampled at edge n gives fall_o high in the cycle after edge n+4 only.
- R4: A line pulse or dropout that is seen by only one clock edge produces no edge pulse, and data_o keeps its level.
- R5: Let m be a clock edge. The newer half of the window is the line samples from edges m-3, m-4 and m-5. The older half is the samples from edges m-6, m-7 and m-8.
  - rise_o is 1 after edge m when at least two of the newer samples are 1 and at least two of the older samples are 0, unless R6 blocks it.
  - fall_o is 1 under the same rule with the levels swapped.
- R6: Two edge pulses of either kind are always at least HOLDOFF_CYCLES+1 cycles apart. A candidate that falls inside this hold-off is discarded.
- R7: After edge m, data_o is the majority of the line samples from edges m-3, m-4 and m-5. When rise_o is 1, data_o is 1. When fall_o is 1, data_o is 0.
- R8: rise_o and fall_o are never 1 in the same cycle, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Asynchronous serial receive line |
| data_o | output | 1 | Filtered line level, aligned with the edge pulses |
| rise_o | output | 1 | One-cycle pulse on a declared rising edge |
| fall_o | output | 1 | One-cycle pulse on a declared falling edge |

## Verification
The hardest case to reach from the ports is a second transition that arrives while the hold-off is still running. When that happens the filtered level moves but no pulse is emitted.

A directed two-cycle dropout places the return edge just after the end of the hold-off window. A back-to-back sweep of all 256 eight-bit line patterns, followed by a long stretch of pseudo-random run lengths from one to four cycles, lands many candidates inside the hold-off window and many just outside it. The bench keeps its own sample history to predict each output cycle by cycle from the voting rule and the spacing rule.

// File: rtl/edge_vote_pkg.sv
// Shared types for the majority-vote edge detector.
package edge_vote_pkg;

    // Majority decisions for the two halves of the sample window.
    typedef struct packed {
        logic newer;   // majority level of the most recent half
        logic older;   // majority level of the earlier half
    } vote_pair_t;

endpackage

// File: rtl/lev_sync_chain.sv
// Metastability synchronizer for the asynchronous receive line.
// Assumes STAGES >= 2. Every flop is preset to the idle level under reset,
// so the chain emits the idle level until real samples pass through.
module lev_sync_chain #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // One synchronizer stage: takes the line or the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ff[i] <= IDLE;
                end else if (i == 0) begin
                    ff[i] <= d_i;
                end else begin
                    ff[i] <= ff[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q_o = ff[STAGES-1];
endmodule

// File: rtl/lev_vote_window.sv
// Sample window after the synchronizer. Tap 0 is the newest sample.
// The lower half is the "newer" group and the upper half the "older" group.
// Each half is reduced to a strict majority level.
// Assumes TAPS is even and each half has an odd number of taps.
module lev_vote_window
    import edge_vote_pkg::*;
#(
    parameter int   TAPS = 6,
    parameter logic IDLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_i,
    output vote_pair_t votes_o
);
    localparam int HALF = TAPS / 2;
    localparam int NEED = HALF / 2 + 1;

    logic [TAPS-1:0] taps;

    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            // Shift one tap per clock; idle level under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    taps[i] <= IDLE;
                end else if (i == 0) begin
                    taps[i] <= sample_i;
                end else begin
                    taps[i] <= taps[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    // Majority reduction of each half.
    always_comb begin
        votes_o.newer = ($countones(taps[HALF-1:0])    >= NEED);
        votes_o.older = ($countones(taps[TAPS-1:HALF]) >= NEED);
    end

    // A uniform window must vote the same level in both halves.
    p_uniform_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&taps) || !(|taps)) |-> (votes_o.newer == votes_o.older));
endmodule

// File: rtl/lev_holdoff.sv
// Hold-off timer. It loads HOLD on an accepted edge and counts down to zero.
// busy_o is high for exactly HOLD cycles after each accepted edge.
// Assumes HOLD >= 2, so that one physical transition cannot be reported twice.
module lev_holdoff #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    // Reload on an accepted edge, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (fire_i) begin
            cnt <= CW'(HOLD);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(HOLD));

    p_busy_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> busy_o);
endmodule

// File: rtl/line_edge_voter.sv
// Glitch-robust edge detector for an asynchronous serial line.
// Path: synchronizer, six-tap majority window, then registered edge and data
// outputs. A hold-off timer gates detection after every accepted edge.
// The data output is registered from the newer-half majority, so it is
// exactly as late as the edge pulses.
// Assumes HOLDOFF_CYCLES >= 2 and an even WINDOW_TAPS with odd halves.
module line_edge_voter
    import edge_vote_pkg::*;
#(
    parameter int   SYNC_STAGES    = 2,
    parameter int   WINDOW_TAPS    = 6,
    parameter int   HOLDOFF_CYCLES = 4,
    parameter logic IDLE_LEVEL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic data_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int GW = $clog2(HOLDOFF_CYCLES + 2);

    logic       synced;
    vote_pair_t votes;
    logic       busy;
    logic       rise_c, fall_c, fire;
    logic       rise_q, fall_q, data_q;

    lev_sync_chain #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LEVEL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (synced)
    );

    lev_vote_window #(.TAPS(WINDOW_TAPS), .IDLE(IDLE_LEVEL)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (synced),
        .votes_o  (votes)
    );

    lev_holdoff #(.HOLD(HOLDOFF_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .busy_o (busy)
    );

    // Edge candidates: the two halves disagree and no hold-off is running.
    always_comb begin
        rise_c = votes.newer && !votes.older && !busy;
        fall_c = !votes.newer && votes.older && !busy;
        fire   = rise_c || fall_c;
    end

    // Register the edge pulses and the filtered level together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            data_q <= IDLE_LEVEL;
        end else begin
            rise_q <= rise_c;
            fall_q <= fall_c;
            data_q <= votes.newer;
        end
    end

    assign rise_o = rise_q;
    assign fall_o = fall_q;
    assign data_o = data_q;

    // ---------------- assertions ----------------
    logic          rst_seen_q;
    logic [GW-1:0] gap_q;
    logic          any_pulse_q;

    // Record that the previous edge was taken in reset.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Count cycles since the last output pulse, saturating past the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            any_pulse_q <= 1'b0;
        end else if (rise_o || fall_o) begin
            gap_q       <= '0;
            any_pulse_q <= 1'b1;
        end else if (gap_q != GW'(HOLDOFF_CYCLES)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        rst_seen_q |-> (data_o == IDLE_LEVEL && !rise_o && !fall_o));

    p_pulse_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o || fall_o) && any_pulse_q) |-> (gap_q == GW'(HOLDOFF_CYCLES)));

    p_rise_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> data_o);

    p_fall_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !data_o);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: tb/tb_line_edge_voter.sv
module tb_line_edge_voter;
    localparam int   HOLD = 3;
    localparam logic IDLE = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_i = IDLE;
    logic data_o, rise_o, fall_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    line_edge_voter #(.HOLDOFF_CYCLES(HOLD), .IDLE_LEVEL(IDLE)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .data_o (data_o),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference history of line samples, one per clock edge outside reset.
    bit s [0:16383];
    int n = 0;
    int last_acc = -100000;
    bit exp_d = IDLE, exp_r = 1'b0, exp_f = 1'b0;
    bit pd = IDLE, pr = 1'b0, pf = 1'b0;

    function automatic bit smp(input int i);
        return (i < 0) ? IDLE : s[i];
    endfunction

    function automatic bit maj(input bit a, input bit b, input bit c);
        return (int'(a) + int'(b) + int'(c)) >= 2;
    endfunction

    // Reference model: voting rule (R5), spacing rule (R6), data rule (R7).
    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; last_acc = -100000;
            exp_d = IDLE; exp_r = 0; exp_f = 0;
            pd = IDLE; pr = 0; pf = 0;
        end else begin
            bit nm, om, cr, cf, ok;
            s[n] = line_i;
            nm = maj(smp(n-2), smp(n-3), smp(n-4));
            om = maj(smp(n-5), smp(n-6), smp(n-7));
            cr = nm && !om;
            cf = !nm && om;
            ok = (n - last_acc) > HOLD;
            exp_d = pd; exp_r = pr; exp_f = pf;
            pd = nm; pr = cr && ok; pf = cf && ok;
            if ((cr || cf) && ok) last_acc = n;
            n++;
        end
    end

    // Compare every cycle against the model during the sweep.
    bit sweep_on = 1'b0;
    int cyc = 0;
    int last_p = -1000;
    always @(negedge clk) begin
        cyc++;
        if (sweep_on) begin
            chk(data_o == exp_d, "R7 data", data_o, exp_d);
            chk(rise_o == exp_r, "R5,R6 rise", rise_o, exp_r);
            chk(fall_o == exp_f, "R5,R6 fall", fall_o, exp_f);
            chk(!(rise_o && fall_o), "R8 exclusive", rise_o + fall_o, 1);
            if (rise_o || fall_o) begin
                chk(cyc - last_p > HOLD, "R6 spacing", cyc - last_p, HOLD + 1);
                last_p = cyc;
            end
        end
    end

    // Drive a step at a negedge; check pulse and level after edges n..n+8.
    task automatic step_check(input bit lvl, input string tag);
        @(negedge clk);
        line_i = lvl;
        for (int k = 0; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (lvl) chk(rise_o == (k == 4), tag, rise_o, k == 4);
            else     chk(fall_o == (k == 4), tag, fall_o, k == 4);
            chk(!(rise_o && fall_o), "R8 exclusive", rise_o + fall_o, 1);
            chk(data_o == ((k >= 4) ? lvl : !lvl), "R7 aligned data", data_o,
                (k >= 4) ? lvl : !lvl);
        end
    endtask

    // A line change seen by one edge only; no pulse, level unchanged.
    task automatic glitch_check(input bit base);
        @(negedge clk);
        line_i = !base;
        @(negedge clk);
        line_i = base;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(!rise_o && !fall_o, "R4 no edge", rise_o + fall_o, 0);
            chk(data_o == base, "R4 level kept", data_o, base);
        end
    endtask

    initial begin
        logic [15:0] lf;
        // R1: reset state and quiet start-up
        repeat (2) @(negedge clk);
        repeat (2) begin
            @(negedge clk);
            chk(data_o == IDLE && !rise_o && !fall_o, "R1 in reset", {data_o, rise_o, fall_o}, 3'b100);
        end
        rst_n = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk(data_o == IDLE && !rise_o && !fall_o, "R1 after release", {data_o, rise_o, fall_o}, 3'b100);
        end
        // R3 then R2: clean steps and their latency
        step_check(1'b0, "R3 fall latency");
        repeat (6) @(negedge clk);
        step_check(1'b1, "R2 rise latency");
        repeat (6) @(negedge clk);
        // R4: one-cycle dropout while high, one-cycle spike while low
        glitch_check(1'b1);
        step_check(1'b0, "R3 fall latency");
        repeat (6) @(negedge clk);
        glitch_check(1'b0);
        step_check(1'b1, "R2 rise latency");
        repeat (6) @(negedge clk);
        // R6: two-cycle dropout; the return edge falls just past the hold-off
        @(negedge clk);
        line_i = 1'b0;
        for (int k = 0; k <= 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(fall_o == (k == 4), "R6 fall of short dropout", fall_o, k == 4);
            chk(rise_o == (k == 8), "R6 rise after hold-off", rise_o, k == 8);
            if (k == 1) line_i = 1'b1;
        end
        // Sweep: every 8-bit pattern, back to back, then pseudo-random runs
        sweep_on = 1'b1;
        for (int p = 0; p < 256; p++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                line_i = p[b];
            end
        end
        lf = 16'hACE1;
        for (int r = 0; r < 1500; r++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            for (int j = 0; j <= int'(lf[1:0]); j++) begin
                @(negedge clk);
                line_i = lf[15];
            end
        end
        repeat (12) @(negedge clk);
        sweep_on = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule